// File: doc/BRIEF.md
# Synthesizer Start-Up Configuration Sequencer

This block brings up an external fractional-N PLL synthesizer after power is applied. It first waits a fixed settling time, counted in clock cycles. It then sends six register writes in a fixed order to a serial word transmitter, one at a time. The four register images are build-time parameters: noise/spur, control, reference divider and main divider.

The two control writes frame the divider loads. The first sets the counter-reset bit (bit 3) before the dividers are loaded, and the last clears it afterwards. Each write carries its own word length, which tells the transmitter how many low-order bits to shift out.

Once the last write is acknowledged, the block raises a done flag. From then on it copies the synthesizer's lock-detect line to a lock indicator output through a two-stage synchronizer. A new reset starts everything again from the settling wait.

Top module: `synth_boot_seq`

## Requirements
- R1: After `rst_ni` is released, `wr_req_o` stays low and rises at the falling edge that follows rising edge number DELAY_CYCLES+1, counted from the release.
- R2: The writes go out in this order: 0x000003, then the noise/spur image, then control with counter reset set, then the reference image, then the main divider image, then control with counter reset cleared. Only the two low bits of each word select the register.
- R3: The word lengths are NS_LEN (11) for the two noise/spur writes, CTRL_LEN (16) for the two control writes, and DIV_LEN (24) for the two divider writes.
- R4: The first control write sends the control image with bit 3 forced to 1. The second control write sends it with bit 3 forced to 0. All other bits equal the image in both writes.
- R5: While a write is pending, `wr_req_o`, `wr_word_o` and `wr_len_o` hold steady until `wr_done_i` is seen. The next write is presented in the cycle after that pulse. A `wr_done_i` pulse with no request pending has no effect.
- R6: `done_o` rises in the cycle after the sixth `wr_done_i`. It then stays high and `wr_req_o` stays low, whatever `wr_done_i` does.
- R7: While `done_o` is low, `lock_led_o` is low, whatever `lock_raw_i` does.
- R8: Once `done_o` is high, `lock_led_o` equals `lock_raw_i` as it was two rising edges earlier.
- R9: A reset at any point, including in the middle of the sequence, drops requests, done and lock indicator at once. The whole sequence then runs again from the settling wait.
- R10: While reset is held, `wr_req_o`, `done_o` and `lock_led_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_req_o | output | 1 | Write pending to the serial transmitter |
| wr_word_o | output | WORD_W | Word to transmit, right-aligned |
| wr_len_o | output | $clog2(WORD_W+1) | Number of bits to shift out |
| wr_done_i | input | 1 | One-cycle pulse from the transmitter when the write is finished |
| lock_raw_i | input | 1 | Asynchronous lock-detect line from the synthesizer |
| lock_led_o | output | 1 | Synchronized lock indicator, gated by done |
| done_o | output | 1 | Sequence complete |

## Verification
The first request is due DELAY_CYCLES+1 rising edges after reset release. The bench counts falling edges from the release and requires the request to appear at exactly that count. Each later request, and the done flag after the last write, is due one edge after the acknowledge pulse, so the bench checks it at the very next falling edge. The acknowledge comes after a random hold, during which word and length are checked on every cycle. The lock indicator lags its input by two rising edges; the bench holds each lock value for two cycles before comparing, and in a directed case it also confirms the old value is still present after only one edge.

// File: rtl/synth_boot_pkg.sv
package synth_boot_pkg;

  typedef enum logic [1:0] {
    SEQ_WAIT  = 2'd0,
    SEQ_ISSUE = 2'd1,
    SEQ_DONE  = 2'd2
  } seq_state_e;

  localparam int unsigned NUM_STEPS = 6;
  localparam int unsigned STEP_W    = $clog2(NUM_STEPS);

  // Order is behaviour: counter reset is set before the divider loads and cleared after them.
  typedef enum logic [STEP_W-1:0] {
    STP_NS_CLR    = 3'd0,
    STP_NS_SET    = 3'd1,
    STP_CTRL_HOLD = 3'd2,
    STP_REF       = 3'd3,
    STP_MAIN      = 3'd4,
    STP_CTRL_RUN  = 3'd5
  } step_e;

endpackage

// File: rtl/boot_delay_timer.sv
module boot_delay_timer #(
  parameter int unsigned DELAY_CYCLES = 5_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic expired_o
);
  localparam int unsigned CNT_W = (DELAY_CYCLES > 1) ? $clog2(DELAY_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DELAY_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             expired_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      expired_q <= 1'b0;
    end else if (!expired_q) begin
      if (cnt_q == LAST) expired_q <= 1'b1;
      else               cnt_q     <= cnt_q + 1'b1;
    end
  end

  assign expired_o = expired_q;
endmodule

// File: rtl/boot_step_ctrl.sv
module boot_step_ctrl
  import synth_boot_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  start_i,
  input  logic  wr_done_i,
  output logic  wr_req_o,
  output step_e step_o,
  output logic  done_o
);
  seq_state_e state_q;
  step_e      step_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_WAIT;
      step_q  <= STP_NS_CLR;
    end else begin
      unique case (state_q)
        SEQ_WAIT: if (start_i) begin
          state_q <= SEQ_ISSUE;
          step_q  <= STP_NS_CLR;
        end
        SEQ_ISSUE: if (wr_done_i) begin
          if (step_q == STP_CTRL_RUN) state_q <= SEQ_DONE;
          else step_q <= step_e'(STEP_W'(step_q + STEP_W'(1)));
        end
        SEQ_DONE: state_q <= SEQ_DONE;
        default:  state_q <= SEQ_WAIT;
      endcase
    end
  end

  assign wr_req_o = (state_q == SEQ_ISSUE);
  assign done_o   = (state_q == SEQ_DONE);
  assign step_o   = step_q;
endmodule

// File: rtl/boot_word_sel.sv
module boot_word_sel
  import synth_boot_pkg::*;
#(
  parameter int unsigned       WORD_W     = 24,
  parameter int unsigned       LEN_W      = 5,
  parameter logic [WORD_W-1:0] CLR_WORD   = 'h000003,
  parameter logic [WORD_W-1:0] NS_IMAGE   = 'h0003C7,
  parameter logic [WORD_W-1:0] CTRL_IMAGE = 'h0001E2,
  parameter logic [WORD_W-1:0] REF_IMAGE  = 'h1440A1,
  parameter logic [WORD_W-1:0] MAIN_IMAGE = 'h3FC060,
  parameter int unsigned       CRST_BIT   = 3,
  parameter int unsigned       NS_LEN     = 11,
  parameter int unsigned       CTRL_LEN   = 16,
  parameter int unsigned       DIV_LEN    = 24
) (
  input  step_e             step_i,
  output logic [WORD_W-1:0] word_o,
  output logic [LEN_W-1:0]  len_o
);
  localparam logic [WORD_W-1:0] CRST_MASK = WORD_W'(1) << CRST_BIT;
  localparam logic [WORD_W-1:0] CTRL_HOLD = CTRL_IMAGE | CRST_MASK;
  localparam logic [WORD_W-1:0] CTRL_RUN  = CTRL_IMAGE & ~CRST_MASK;

  always_comb begin
    word_o = CLR_WORD;
    len_o  = LEN_W'(NS_LEN);
    unique case (step_i)
      STP_NS_CLR:    begin word_o = CLR_WORD;   len_o = LEN_W'(NS_LEN);   end
      STP_NS_SET:    begin word_o = NS_IMAGE;   len_o = LEN_W'(NS_LEN);   end
      STP_CTRL_HOLD: begin word_o = CTRL_HOLD;  len_o = LEN_W'(CTRL_LEN); end
      STP_REF:       begin word_o = REF_IMAGE;  len_o = LEN_W'(DIV_LEN);  end
      STP_MAIN:      begin word_o = MAIN_IMAGE; len_o = LEN_W'(DIV_LEN);  end
      STP_CTRL_RUN:  begin word_o = CTRL_RUN;   len_o = LEN_W'(CTRL_LEN); end
      default:       begin word_o = CLR_WORD;   len_o = LEN_W'(NS_LEN);   end
    endcase
  end
endmodule

// File: rtl/lock_follow.sv
module lock_follow #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enable_i,
  input  logic lock_raw_i,
  output logic lock_o
);
  logic [SYNC_STAGES-1:0] sync_q;

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[s] <= 1'b0;
        else if (s == 0) sync_q[s] <= lock_raw_i;
        else sync_q[s] <= sync_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign lock_o = enable_i & sync_q[SYNC_STAGES-1];
endmodule

// File: rtl/synth_boot_seq.sv
module synth_boot_seq
  import synth_boot_pkg::*;
#(
  parameter int unsigned       DELAY_CYCLES = 5_000_000,
  parameter int unsigned       WORD_W       = 24,
  parameter logic [WORD_W-1:0] CLR_WORD     = 'h000003,
  parameter logic [WORD_W-1:0] NS_IMAGE     = 'h0003C7,
  parameter logic [WORD_W-1:0] CTRL_IMAGE   = 'h0001E2,
  parameter logic [WORD_W-1:0] REF_IMAGE    = 'h1440A1,
  parameter logic [WORD_W-1:0] MAIN_IMAGE   = 'h3FC060,
  parameter int unsigned       CRST_BIT     = 3,
  parameter int unsigned       NS_LEN       = 11,
  parameter int unsigned       CTRL_LEN     = 16,
  parameter int unsigned       DIV_LEN      = 24,
  parameter int unsigned       SYNC_STAGES  = 2
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  output logic                         wr_req_o,
  output logic [WORD_W-1:0]            wr_word_o,
  output logic [$clog2(WORD_W+1)-1:0]  wr_len_o,
  input  logic                         wr_done_i,
  input  logic                         lock_raw_i,
  output logic                         lock_led_o,
  output logic                         done_o
);
  localparam int unsigned LEN_W = $clog2(WORD_W + 1);

  logic  expired;
  step_e step;

  boot_delay_timer #(.DELAY_CYCLES(DELAY_CYCLES)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .expired_o (expired)
  );

  boot_step_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (expired),
    .wr_done_i (wr_done_i),
    .wr_req_o  (wr_req_o),
    .step_o    (step),
    .done_o    (done_o)
  );

  boot_word_sel #(
    .WORD_W     (WORD_W),
    .LEN_W      (LEN_W),
    .CLR_WORD   (CLR_WORD),
    .NS_IMAGE   (NS_IMAGE),
    .CTRL_IMAGE (CTRL_IMAGE),
    .REF_IMAGE  (REF_IMAGE),
    .MAIN_IMAGE (MAIN_IMAGE),
    .CRST_BIT   (CRST_BIT),
    .NS_LEN     (NS_LEN),
    .CTRL_LEN   (CTRL_LEN),
    .DIV_LEN    (DIV_LEN)
  ) u_words (
    .step_i (step),
    .word_o (wr_word_o),
    .len_o  (wr_len_o)
  );

  lock_follow #(.SYNC_STAGES(SYNC_STAGES)) u_lock (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .enable_i   (done_o),
    .lock_raw_i (lock_raw_i),
    .lock_o     (lock_led_o)
  );
endmodule

// File: rtl/synth_boot_seq_chk.sv
module synth_boot_seq_chk #(
  parameter int unsigned WORD_W   = 24,
  parameter int unsigned NS_LEN   = 11,
  parameter int unsigned CTRL_LEN = 16,
  parameter int unsigned DIV_LEN  = 24
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        wr_req_o,
  input logic [WORD_W-1:0]           wr_word_o,
  input logic [$clog2(WORD_W+1)-1:0] wr_len_o,
  input logic                        wr_done_i,
  input logic                        lock_raw_i,
  input logic                        lock_led_o,
  input logic                        done_o
);
  localparam int unsigned LEN_W = $clog2(WORD_W + 1);

  p_hold_pending_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req_o && !wr_done_i) |=> (wr_req_o && $stable(wr_word_o) && $stable(wr_len_o)));

  p_len_legal_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o |-> (wr_len_o == LEN_W'(NS_LEN) || wr_len_o == LEN_W'(CTRL_LEN) ||
                  wr_len_o == LEN_W'(DIV_LEN)));

  p_done_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o);

  p_quiet_after_done_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !wr_req_o);

  p_led_gated_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> !lock_led_o);

  p_led_follow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && $past(done_o) && $past(done_o, 2)) |-> (lock_led_o == $past(lock_raw_i, 2)));
endmodule

bind synth_boot_seq synth_boot_seq_chk #(
  .WORD_W   (WORD_W),
  .NS_LEN   (NS_LEN),
  .CTRL_LEN (CTRL_LEN),
  .DIV_LEN  (DIV_LEN)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_req_o   (wr_req_o),
  .wr_word_o  (wr_word_o),
  .wr_len_o   (wr_len_o),
  .wr_done_i  (wr_done_i),
  .lock_raw_i (lock_raw_i),
  .lock_led_o (lock_led_o),
  .done_o     (done_o)
);

// File: tb/synth_boot_seq_test.sv
module synth_boot_seq_test;
  localparam int unsigned DLY = 20;
  localparam logic [23:0] NS  = 24'h0003C7;
  localparam logic [23:0] CT  = 24'h00A5CE;  // bit 3 already set in the image
  localparam logic [23:0] RF  = 24'h1440A1;
  localparam logic [23:0] MN  = 24'h3FC060;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_done = 1'b0;
  logic        lock_raw = 1'b0;
  logic        wr_req, lock_led, done;
  logic [23:0] wr_word;
  logic [4:0]  wr_len;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  synth_boot_seq #(
    .DELAY_CYCLES (DLY),
    .NS_IMAGE     (NS),
    .CTRL_IMAGE   (CT),
    .REF_IMAGE    (RF),
    .MAIN_IMAGE   (MN)
  ) uut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .wr_req_o   (wr_req),
    .wr_word_o  (wr_word),
    .wr_len_o   (wr_len),
    .wr_done_i  (wr_done),
    .lock_raw_i (lock_raw),
    .lock_led_o (lock_led),
    .done_o     (done)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] exp_word(input int k);
    case (k)
      0: return 24'h000003;
      1: return NS;
      2: return CT | 24'h000008;
      3: return RF;
      4: return MN;
      default: return CT & ~24'h000008;
    endcase
  endfunction

  function automatic logic [4:0] exp_len(input int k);
    case (k)
      0, 1: return 5'd11;
      2, 5: return 5'd16;
      default: return 5'd24;
    endcase
  endfunction

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // R10 / R9: reset drops everything immediately
  task automatic apply_reset();
    @(negedge clk);
    wr_done = 1'b0;
    lock_raw = 1'b1;
    rst_n = 1'b0;
    #1;
    chk(!wr_req && !done && !lock_led, "R9", {wr_req, done, lock_led}, 3'b000);
    @(negedge clk);
    chk(!wr_req && !done && !lock_led, "R10", {wr_req, done, lock_led}, 3'b000);
    rst_n = 1'b1;
  endtask

  task automatic wait_start(input bit spurious);
    int n = 0;
    bit seen = 1'b0;
    for (int i = 0; i < int'(DLY) + 10; i++) begin
      @(negedge clk);
      n++;
      wr_done = 1'b0;
      if (lock_led) chk(1'b0, "R7", lock_led, 1'b0);
      if (wr_req) begin seen = 1'b1; break; end
      if (spurious && n < int'(DLY) - 2 && (n % 4) == 1) wr_done = 1'b1;
    end
    chk(seen && n == int'(DLY) + 1, "R1", n, DLY + 1);
  endtask

  task automatic run_writes(input int upto);
    for (int k = 0; k < upto; k++) begin
      int lat;
      chk(wr_req, "R5", wr_req, 1'b1);
      chk(wr_word == exp_word(k), (k == 2 || k == 5) ? "R4" : "R2", wr_word, exp_word(k));
      chk(wr_len == exp_len(k), "R3", wr_len, exp_len(k));
      lat = $urandom_range(0, 4);
      for (int c = 0; c < lat; c++) begin
        lock_raw = 1'($urandom_range(0, 1));
        @(negedge clk);
        chk(wr_req && wr_word == exp_word(k) && wr_len == exp_len(k), "R5", wr_word, exp_word(k));
        chk(!lock_led && !done, "R7", {lock_led, done}, 2'b00);
      end
      wr_done = 1'b1;
      @(negedge clk);
      wr_done = 1'b0;
      if (k == 5) chk(!wr_req && done, "R6", {wr_req, done}, 2'b01);
    end
  endtask

  task automatic lock_phase(input int n);
    lock_raw = 1'b0;
    repeat (3) @(negedge clk);
    lock_raw = 1'b1;
    @(negedge clk);
    chk(lock_led == 1'b0, "R8", lock_led, 1'b0);
    @(negedge clk);
    chk(lock_led == 1'b1, "R8", lock_led, 1'b1);
    for (int i = 0; i < n; i++) begin
      logic b;
      b = 1'($urandom_range(0, 1));
      lock_raw = b;
      if (i % 5 == 3) wr_done = 1'b1;
      @(negedge clk);
      wr_done = 1'b0;
      @(negedge clk);
      chk(lock_led == b, "R8", lock_led, b);
      chk(done && !wr_req, "R6", {done, wr_req}, 2'b10);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    report();
  end

  initial begin
    void'($urandom(32'd4242));
    apply_reset();
    wait_start(1'b0);
    run_writes(6);
    lock_phase(20);

    // R9: restart after completion, spurious acknowledges during the wait
    apply_reset();
    wait_start(1'b1);
    run_writes(3);
    // R9: reset in the middle of the sequence
    apply_reset();
    wait_start(1'b1);
    run_writes(6);
    lock_phase(20);
    report();
  end
endmodule